// File: doc/BRIEF.md
# Interrupt Pending and Request Unit

This block keeps an eight-entry interrupt-pending vector for a processor's system-control coprocessor and decides when the pipeline must take an interrupt exception. Individual lines are set by post strobes and reset by clear strobes, each carrying a line index. A single wipe strobe empties the whole vector. An on-core timer comparator also feeds the vector. When the running count equals the compare value and the count is nonzero, the comparator sets the line chosen by a three-bit select field. A write to the compare value retires that line again.

The vector is read back as the pending field of the cause register. A flag reports whether any line is pending, whatever the mask. The interrupt request is registered. It is raised only when the global enable is on, neither the exception-level bit nor the error-level bit is set, and at least one pending line is also enabled in the eight-bit mask. Mask bit k and pending bit k describe the same line.

Top module: `irq_pend_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, `pend_o` is 8'h00, `any_pend_o` is 0 and `irq_o` is 0.
- R2: A post with an index from 0 to 7 sets pending bit `post_idx_i` at the next rising clock edge. Every other bit not touched by another source that cycle keeps its value.
- R3: A clear with an index from 0 to 7 resets only pending bit `clr_idx_i` at the next edge. A clear beats a post or a timer set aimed at the same bit in the same cycle.
- R4: `clr_all_i` drives every pending bit to 0 at the next edge. This overrides any post or timer set in that cycle.
- R5: `irq_o` is a register. After each edge it equals `ie_i & ~exl_i & ~erl_i & |(im_i & pend_o)`, where every term is the value seen just before that edge.
- R6: `any_pend_o` is 1 exactly when `pend_o` is nonzero, independent of `im_i`, `ie_i`, `exl_i` and `erl_i`.
- R7: The index inputs are 4 bits wide. A post or clear whose index is 8 to 15 has no effect on `pend_o`.
- R8: When `count_i == compare_i` and `count_i != 0`, pending bit `tmr_sel_i` is set at the next edge. When both values are 0, the comparator sets nothing.
- R9: `cmp_wr_i` clears pending bit `tmr_sel_i` at the next edge. This holds even when the count matches the compare value in the same cycle, and even when a post targets that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_vld_i | input | 1 | Post strobe |
| post_idx_i | input | 4 | Line index for a post |
| clr_vld_i | input | 1 | Clear strobe |
| clr_idx_i | input | 4 | Line index for a clear |
| clr_all_i | input | 1 | Wipe every pending line |
| ie_i | input | 1 | Global interrupt enable |
| exl_i | input | 1 | Exception-level bit; blocks requests |
| erl_i | input | 1 | Error-level bit; blocks requests |
| im_i | input | 8 | Per-line interrupt mask |
| tmr_sel_i | input | 3 | Pending line driven by the timer |
| count_i | input | 32 | Running count value |
| compare_i | input | 32 | Timer compare value |
| cmp_wr_i | input | 1 | Strobe: compare value is being written |
| pend_o | output | 8 | Pending vector |
| any_pend_o | output | 1 | Some line pending |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The properties assume that every input is stable around the rising edge and is defined once reset has been released. They also assume that the timer select and the compare write refer to the select value present in that same cycle. The bench changes every input only on the falling edge and never leaves an input undriven. Its random phase draws indices 0 to 9, so that out-of-range posts and clears occur. It also keeps the count and compare values in a small range, so that matches, matches on zero, and compare writes that collide with matches all occur often.

// File: rtl/ipu_pkg.sv
package ipu_pkg;

  localparam int LINES_DEF = 8;
  localparam int IDX_W_DEF = 4;
  localparam int CNT_W_DEF = 32;

  typedef struct packed {
    logic ie;
    logic exl;
    logic erl;
  } gate_ctl_t;

  // The request may leave only when enabled and neither level bit is set.
  function automatic logic gate_open(gate_ctl_t c);
    return c.ie && !c.exl && !c.erl;
  endfunction

  // A request exists when some pending line is also unmasked.
  function automatic logic masked_any(logic [LINES_DEF-1:0] mask,
                                      logic [LINES_DEF-1:0] pend);
    return |(mask & pend);
  endfunction

  // The comparator fires on equality, except when both values are zero.
  function automatic logic cmp_hit(logic [CNT_W_DEF-1:0] cnt,
                                   logic [CNT_W_DEF-1:0] cmp);
    return (cnt == cmp) && (cnt != '0);
  endfunction

endpackage

// File: rtl/ipu_line_dec.sv
module ipu_line_dec #(
  parameter int LINES = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [LINES-1:0] hot_o
);

  // One comparator per line; indexes past the last line match nothing.
  for (genvar g = 0; g < LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    assign hot_o[g] = vld_i && (idx_i == MY_IDX);
  end

  // R2
  dec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hot_o));

  // R7
  dec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |-> (hot_o == '0));

endmodule

// File: rtl/ipu_timer.sv
module ipu_timer
  import ipu_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic             cmp_wr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             match_o,
  output logic [LINES-1:0] set_o,
  output logic [LINES-1:0] clr_o
);

  logic [LINES-1:0] sel_hot;

  assign match_o = cmp_hit(count_i, compare_i);

  for (genvar g = 0; g < LINES; g++) begin : g_route
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(g);
    assign sel_hot[g] = (sel_i == MY_SEL);
  end

  assign set_o = match_o  ? sel_hot : '0;
  assign clr_o = cmp_wr_i ? sel_hot : '0;

  // R8
  tmr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_i == '0) |-> (set_o == '0));

  // R9
  tmr_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_i |-> ($countones(clr_o) == 1));

endmodule

// File: rtl/ipu_vector.sv
module ipu_vector #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] set_i,
  input  logic [LINES-1:0] clr_i,
  input  logic             wipe_i,
  output logic [LINES-1:0] q_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_bit
    // Priority inside one cell: wipe, then clear, then set.
    always_ff @(posedge clk) begin
      if (!rst_n)         q_o[g] <= 1'b0;
      else if (wipe_i)    q_o[g] <= 1'b0;
      else if (clr_i[g])  q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;
    end

    // R2
    bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[g] && !clr_i[g] && !wipe_i) |=> q_o[g]);

    // R3
    bit_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i[g] |=> !q_o[g]);

    // R4
    bit_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wipe_i |=> !q_o[g]);

    // R7
    bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_i[g] && !clr_i[g] && !wipe_i) |=> $stable(q_o[g]));
  end

endmodule

// File: rtl/ipu_gate.sv
module ipu_gate
  import ipu_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  gate_ctl_t        ctl_i,
  input  logic [LINES-1:0] mask_i,
  input  logic [LINES-1:0] pend_i,
  output logic             irq_o
);

  logic want;

  assign want = gate_open(ctl_i) && masked_any(mask_i, pend_i);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= want;
  end

  // R5
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_i.ie || ctl_i.exl || ctl_i.erl) |=> !irq_o);

  // R5
  gate_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mask_i & pend_i) == '0) |=> !irq_o);

  // R5
  gate_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.ie && !ctl_i.exl && !ctl_i.erl && ((mask_i & pend_i) != '0)) |=> irq_o);

endmodule

// File: rtl/irq_pend_unit.sv
module irq_pend_unit
  import ipu_pkg::*;
#(
  parameter int LINES = LINES_DEF,
  parameter int IDX_W = IDX_W_DEF,
  parameter int CNT_W = CNT_W_DEF,
  localparam int SEL_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_vld_i,
  input  logic [IDX_W-1:0] post_idx_i,
  input  logic             clr_vld_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  input  logic             clr_all_i,
  input  logic             ie_i,
  input  logic             exl_i,
  input  logic             erl_i,
  input  logic [LINES-1:0] im_i,
  input  logic [SEL_W-1:0] tmr_sel_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] compare_i,
  input  logic             cmp_wr_i,
  output logic [LINES-1:0] pend_o,
  output logic             any_pend_o,
  output logic             irq_o
);

  logic [LINES-1:0] post_hot;
  logic [LINES-1:0] clr_hot;
  logic [LINES-1:0] tmr_set;
  logic [LINES-1:0] tmr_clr;
  logic [LINES-1:0] set_all;
  logic [LINES-1:0] clr_any;
  logic             tmr_match;
  gate_ctl_t        ctl;

  ipu_line_dec #(.LINES(LINES), .IDX_W(IDX_W)) u_post_dec (
    .clk(clk), .rst_n(rst_n), .vld_i(post_vld_i), .idx_i(post_idx_i), .hot_o(post_hot)
  );

  ipu_line_dec #(.LINES(LINES), .IDX_W(IDX_W)) u_clr_dec (
    .clk(clk), .rst_n(rst_n), .vld_i(clr_vld_i), .idx_i(clr_idx_i), .hot_o(clr_hot)
  );

  ipu_timer #(.LINES(LINES), .CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .compare_i(compare_i),
    .cmp_wr_i(cmp_wr_i), .sel_i(tmr_sel_i), .match_o(tmr_match),
    .set_o(tmr_set), .clr_o(tmr_clr)
  );

  assign set_all = post_hot | tmr_set;
  assign clr_any = clr_hot | tmr_clr;

  ipu_vector #(.LINES(LINES)) u_vec (
    .clk(clk), .rst_n(rst_n), .set_i(set_all), .clr_i(clr_any),
    .wipe_i(clr_all_i), .q_o(pend_o)
  );

  assign ctl = '{ie: ie_i, exl: exl_i, erl: erl_i};

  ipu_gate #(.LINES(LINES)) u_gate (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .mask_i(im_i), .pend_i(pend_o), .irq_o(irq_o)
  );

  assign any_pend_o = |pend_o;

  // R9
  top_cmpwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_i |=> !pend_o[$past(tmr_sel_i)]);

  // R8
  top_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_match && !cmp_wr_i && !clr_all_i &&
     !(clr_vld_i && (clr_idx_i == IDX_W'(tmr_sel_i))))
    |=> pend_o[$past(tmr_sel_i)]);

  // R7
  top_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (post_vld_i && (post_idx_i >= IDX_W'(LINES)) && !clr_vld_i && !clr_all_i &&
     !cmp_wr_i && !tmr_match) |=> (pend_o == $past(pend_o)));

  // R4
  top_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_i |=> !any_pend_o);

endmodule

// File: tb/irq_pend_unit_test.sv
module irq_pend_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        post_vld;
  logic [3:0]  post_idx;
  logic        clr_vld;
  logic [3:0]  clr_idx;
  logic        clr_all;
  logic        ie, exl, erl;
  logic [7:0]  im;
  logic [2:0]  tmr_sel;
  logic [31:0] count, compare;
  logic        cmp_wr;
  logic [7:0]  pend;
  logic        any_pend;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  int model_pend = 0;
  bit model_irq  = 0;

  always #5 clk = ~clk;

  irq_pend_unit uut (
    .clk(clk), .rst_n(rst_n), .post_vld_i(post_vld), .post_idx_i(post_idx),
    .clr_vld_i(clr_vld), .clr_idx_i(clr_idx), .clr_all_i(clr_all),
    .ie_i(ie), .exl_i(exl), .erl_i(erl), .im_i(im), .tmr_sel_i(tmr_sel),
    .count_i(count), .compare_i(compare), .cmp_wr_i(cmp_wr),
    .pend_o(pend), .any_pend_o(any_pend), .irq_o(irq)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    post_vld = 0; post_idx = 0; clr_vld = 0; clr_idx = 0; clr_all = 0;
    cmp_wr = 0; count = 0; compare = 0;
  endtask

  // One clock: predict from the inputs held now, cross the edge, compare at the falling edge.
  task automatic tick();
    int nxt = model_pend;
    bit nirq;
    nirq = ie && !exl && !erl && ((int'(im) & model_pend) != 0);
    if (post_vld && post_idx < 8) nxt = nxt | (1 << post_idx);
    if (count == compare && count != 0) nxt = nxt | (1 << tmr_sel);
    if (clr_vld && clr_idx < 8) nxt = nxt & ~(1 << clr_idx);
    if (cmp_wr) nxt = nxt & ~(1 << tmr_sel);
    if (clr_all) nxt = 0;
    @(posedge clk);
    model_pend = nxt;
    model_irq  = nirq;
    @(negedge clk);
    chk("R2 pend vs model", int'(pend), model_pend);
    chk("R6 any_pend vs model", int'(any_pend), int'(model_pend != 0));
    chk("R5 irq vs model", int'(irq), int'(model_irq));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); ie = 0; exl = 0; erl = 0; im = 0; tmr_sel = 0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 pend in reset", int'(pend), 0);
    chk("R1 any_pend in reset", int'(any_pend), 0);
    chk("R1 irq in reset", int'(irq), 0);
    rst_n = 1;
    tick();
    chk("R1 pend after release", int'(pend), 0);

    // R2: post line 3
    post_vld = 1; post_idx = 3; tick(); idle();
    chk("R2 post line 3", int'(pend), 8'h08);
    // R7: index 9 ignored
    post_vld = 1; post_idx = 9; tick(); idle();
    chk("R7 post index 9", int'(pend), 8'h08);
    clr_vld = 1; clr_idx = 12; tick(); idle();
    chk("R7 clear index 12", int'(pend), 8'h08);
    // R3: clear beats post on the same line
    post_vld = 1; post_idx = 5; clr_vld = 1; clr_idx = 5; tick(); idle();
    chk("R3 clear wins", int'(pend), 8'h08);
    clr_vld = 1; clr_idx = 3; tick(); idle();
    chk("R3 clear line 3", int'(pend), 8'h00);

    // R5: request one cycle after pending+mask
    ie = 1; im = 8'h02; post_vld = 1; post_idx = 1; tick(); idle();
    chk("R5 irq not yet", int'(irq), 0);
    tick();
    chk("R5 irq raised", int'(irq), 1);
    exl = 1; tick();
    chk("R5 irq blocked by exl", int'(irq), 0);
    exl = 0; erl = 1; tick();
    chk("R5 irq blocked by erl", int'(irq), 0);
    erl = 0; im = 8'h00; tick();
    chk("R6 any_pend with mask off", int'(any_pend), 1);
    chk("R5 irq mask off", int'(irq), 0);

    // R8: timer
    tmr_sel = 6; count = 0; compare = 0; tick();
    chk("R8 no set on zero", int'(pend[6]), 0);
    count = 7; compare = 7; tick();
    chk("R8 timer sets line 6", int'(pend[6]), 1);
    // R9: compare write beats match and post
    cmp_wr = 1; post_vld = 1; post_idx = 6; tick(); idle();
    chk("R9 compare write clears", int'(pend[6]), 0);
    // R4: clear-all beats post
    post_vld = 1; post_idx = 2; clr_all = 1; tick(); idle();
    chk("R4 clear all", int'(pend), 0);

    // Random phase
    for (int n = 0; n < 1500; n++) begin
      post_vld = ($urandom % 2) == 0;
      post_idx = 4'($urandom % 10);
      clr_vld  = ($urandom % 10) < 3;
      clr_idx  = 4'($urandom % 10);
      clr_all  = ($urandom % 40) == 0;
      ie       = ($urandom % 5) != 0;
      exl      = ($urandom % 10) == 0;
      erl      = ($urandom % 10) == 0;
      im       = 8'($urandom);
      tmr_sel  = 3'($urandom);
      count    = $urandom % 4;
      compare  = $urandom % 4;
      cmp_wr   = ($urandom % 10) == 0;
      tick();
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule